// File: doc/BRIEF.md
# Two-Step Egress Timestamp FIFO

This block queues egress timestamps for frames that need two-step precision time handling. Software collects them later through a simple register view. The egress path reports each such frame once, with its transmit nanosecond stamp, its egress port and the identifier that software tagged on the frame.

The block turns that report into two linked entries that are written together. The first entry is a transmit stamp holding the nanosecond value. The second entry has the transmit flag clear and carries the identifier, split across the stamp field and the 8-bit sub-nanosecond field. Software reads the entry at the head through a status view and a data view. The status view gives valid, overflow, the transmit flag and the port. The data view gives the stamp and the sub-nanosecond field. A one-cycle next strobe removes the head entry.

A frame is stored only when both of its entries fit, so a pair is never split. A frame that does not fit is dropped as a whole, and a sticky overflow flag records the loss until software clears it.

Top module: `ts2_stamp_fifo`

## Requirements
- R1: After reset is released, valid (`st_valid`) and overflow (`st_ovf`) both read 0.
- R2: An accepted push makes a transmit entry available first: `st_is_tx`=1, `st_port`=`eg_port`, `hd_stamp`=`eg_nsec`, `hd_subns`=0.
- R3: The entry right after a transmit entry has `st_is_tx`=0 and the same port. Its fields carry the 9-bit identifier `eg_fid` (0..511) as `hd_stamp`=`eg_fid`>>8 and `hd_subns`=`eg_fid`[7:0], so that identifier = (`hd_stamp`<<8)|`hd_subns`, and this holds at 0 and at 511.
- R4: Entries leave in push order. A cycle with `rd_next`=1 removes the head, and the head fields hold steady while `rd_next`=0.
- R5: `rd_next` while the FIFO is empty has no effect: it leaves the FIFO empty and changes neither the overflow flag nor later entries.
- R6: A push is accepted only when the occupancy before that cycle's pop is at most DEPTH-2. Otherwise both entries are dropped and `st_ovf` reads 1 from the next cycle on.
- R7: `st_ovf` stays 1 until a cycle with `ovf_clear`=1 and no dropped push. A drop in the same cycle as a clear leaves it set.
- R8: `st_valid` is 0 exactly when the FIFO is empty, and the head fields read 0 then.
- R9: A push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| eg_push | input | 1 | One frame report from the egress path |
| eg_port | input | 7 | Egress port of the frame |
| eg_nsec | input | 30 | Transmit nanosecond stamp |
| eg_fid | input | 9 | Frame identifier tagged by software |
| rd_next | input | 1 | Remove the head entry |
| ovf_clear | input | 1 | Clear the overflow flag |
| st_valid | output | 1 | Head entry present |
| st_ovf | output | 1 | Sticky overflow flag |
| st_is_tx | output | 1 | Head entry is a transmit stamp |
| st_port | output | 7 | Port of the head entry |
| hd_stamp | output | 30 | Stamp field of the head entry |
| hd_subns | output | 8 | Sub-nanosecond field of the head entry |

## Verification
On every cycle, the assertions check these properties: occupancy never exceeds the depth, an odd occupancy always leaves an identifier entry at the head, the head holds steady without a pop, a refused push raises overflow, overflow persists without a clear, and a pop on an empty FIFO leaves it empty. Only the bench scenarios can show the rest. These are the exact field encoding of each pair, including identifiers 0 and 511, the push order across many frames, the admission boundary when full, and a push and pop landing in the same cycle. They also cover a clear that coincides with a drop.

// File: rtl/ts2_pkg.sv
package ts2_pkg;
  localparam int PORT_W  = 7;
  localparam int NSEC_W  = 30;
  localparam int FID_W   = 9;
  localparam int SUBNS_W = 8;

  typedef struct packed {
    logic               is_tx;
    logic [PORT_W-1:0]  port;
    logic [NSEC_W-1:0]  stamp;
    logic [SUBNS_W-1:0] subns;
  } entry_t;
endpackage

// File: rtl/ts2_pair_pack.sv
module ts2_pair_pack
  import ts2_pkg::*;
(
  input  logic [PORT_W-1:0] port_i,
  input  logic [NSEC_W-1:0] nsec_i,
  input  logic [FID_W-1:0]  fid_i,
  output entry_t            tx_o,
  output entry_t            id_o
);
  localparam int HI_W = FID_W - SUBNS_W;

  always_comb begin
    tx_o.is_tx = 1'b1;
    tx_o.port  = port_i;
    tx_o.stamp = nsec_i;
    tx_o.subns = '0;
    id_o.is_tx = 1'b0;
    id_o.port  = port_i;
    id_o.stamp = NSEC_W'(fid_i[FID_W-1 -: HI_W]);
    id_o.subns = fid_i[SUBNS_W-1:0];
  end
endmodule

// File: rtl/ts2_pair_store.sv
module ts2_pair_store
  import ts2_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                   clk,
  input  logic                   rst_ni,
  input  logic                   wr_en,
  input  entry_t                 wr_a,
  input  entry_t                 wr_b,
  input  logic                   rd_en,
  output entry_t                 head_o,
  output logic [$clog2(DEPTH):0] cnt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  entry_t        mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wr_ptr_p1;
  logic [CW-1:0] cnt_q, cnt_d;

  assign wr_ptr_p1 = wr_ptr_q + AW'(1);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en) begin
      wr_ptr_d = wr_ptr_q + AW'(2);
      cnt_d    = cnt_d + CW'(2);
    end
    if (rd_en) begin
      rd_ptr_d = rd_ptr_q + AW'(1);
      cnt_d    = cnt_d - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_ptr_q == AW'(i))) begin
        mem[i] <= wr_a;
      end else if (wr_en && (wr_ptr_p1 == AW'(i))) begin
        mem[i] <= wr_b;
      end
    end
  end

  assign head_o = mem[rd_ptr_q];
  assign cnt_o  = cnt_q;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_odd_head_is_id_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q[0] |-> !head_o.is_tx);
  assert_head_steady_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_q != '0) && !rd_en |=> $stable(head_o));
endmodule

// File: rtl/ts2_sticky_flag.sv
module ts2_sticky_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    q_q && !clr_i |=> q_q);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    set_i |=> q_q);
endmodule

// File: rtl/ts2_stamp_fifo.sv
module ts2_stamp_fifo
  import ts2_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eg_push,
  input  logic [PORT_W-1:0] eg_port,
  input  logic [NSEC_W-1:0] eg_nsec,
  input  logic [FID_W-1:0]  eg_fid,
  input  logic              rd_next,
  input  logic              ovf_clear,
  output logic              st_valid,
  output logic              st_ovf,
  output logic              st_is_tx,
  output logic [PORT_W-1:0] st_port,
  output logic [NSEC_W-1:0] hd_stamp,
  output logic [SUBNS_W-1:0] hd_subns
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    rst_sync_q;
  logic          rst_ni;
  entry_t        tx_e, id_e, head;
  logic [CW-1:0] cnt;
  logic          accept, drop, rd_en, not_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ts2_pair_pack u_pack (
    .port_i (eg_port),
    .nsec_i (eg_nsec),
    .fid_i  (eg_fid),
    .tx_o   (tx_e),
    .id_o   (id_e)
  );

  assign not_empty = (cnt != '0);
  assign accept    = eg_push && (cnt <= CW'(DEPTH - 2));
  assign drop      = eg_push && !accept;
  assign rd_en     = rd_next && not_empty;

  ts2_pair_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr_en  (accept),
    .wr_a   (tx_e),
    .wr_b   (id_e),
    .rd_en  (rd_en),
    .head_o (head),
    .cnt_o  (cnt)
  );

  ts2_sticky_flag u_ovf (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set_i  (drop),
    .clr_i  (ovf_clear),
    .q_o    (st_ovf)
  );

  always_comb begin
    st_valid = not_empty;
    st_is_tx = not_empty ? head.is_tx : 1'b0;
    st_port  = not_empty ? head.port  : '0;
    hd_stamp = not_empty ? head.stamp : '0;
    hd_subns = not_empty ? head.subns : '0;
  end

  assert_empty_pop_ignored_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    !st_valid && rd_next && !eg_push |=> !st_valid);
  assert_refused_push_flags_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    eg_push && (cnt > CW'(DEPTH - 2)) |=> st_ovf);
  assert_push_makes_valid_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    eg_push && !st_valid |=> st_valid);
endmodule

// File: tb/ts2_stamp_fifo_test.sv
`timescale 1ns/1ps
module ts2_stamp_fifo_test;
  localparam int DEPTH = 16;

  typedef struct {
    bit          is_tx;
    int unsigned port;
    int unsigned stamp;
    int unsigned subns;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eg_push = 1'b0, rd_next = 1'b0, ovf_clear = 1'b0;
  logic [6:0]  eg_port = '0;
  logic [29:0] eg_nsec = '0;
  logic [8:0]  eg_fid = '0;
  logic        st_valid, st_ovf, st_is_tx;
  logic [6:0]  st_port;
  logic [29:0] hd_stamp;
  logic [7:0]  hd_subns;

  exp_t exp_q[$];
  bit   exp_ovf = 1'b0;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ts2_stamp_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .eg_push(eg_push), .eg_port(eg_port),
    .eg_nsec(eg_nsec), .eg_fid(eg_fid), .rd_next(rd_next), .ovf_clear(ovf_clear),
    .st_valid(st_valid), .st_ovf(st_ovf), .st_is_tx(st_is_tx), .st_port(st_port),
    .hd_stamp(hd_stamp), .hd_subns(hd_subns)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, called just after a falling edge.
  task automatic step(bit ps, int unsigned pt, int unsigned ns, int unsigned fid,
                      bit pp, bit cl);
    bit acc;
    exp_t a, b;
    eg_push = ps; eg_port = 7'(pt); eg_nsec = 30'(ns); eg_fid = 9'(fid);
    rd_next = pp; ovf_clear = cl;
    acc = ps && (exp_q.size() <= DEPTH - 2);
    if (pp && exp_q.size() > 0) void'(exp_q.pop_front());
    if (acc) begin
      a = '{1'b1, pt, ns, 0};
      b = '{1'b0, pt, fid >> 8, fid & 8'hFF};
      exp_q.push_back(a);
      exp_q.push_back(b);
    end
    if (ps && !acc) exp_ovf = 1'b1;
    else if (cl)    exp_ovf = 1'b0;
    @(negedge clk);
    eg_push = 1'b0; rd_next = 1'b0; ovf_clear = 1'b0;
  endtask

  // Monitor: compare the head against the scoreboard front.
  task automatic check_head(string req);
    check({req, " R7 overflow"}, st_ovf, exp_ovf);
    if (exp_q.size() == 0) begin
      check({req, " R8 valid"}, st_valid, 0);
      check({req, " R8 stamp"}, hd_stamp, 0);
      check({req, " R8 subns"}, hd_subns, 0);
    end else begin
      check({req, " R8 valid"}, st_valid, 1);
      check({req, " is_tx"}, st_is_tx, exp_q[0].is_tx);
      check({req, " port"},  st_port,  exp_q[0].port);
      check({req, " stamp"}, hd_stamp, exp_q[0].stamp);
      check({req, " subns"}, hd_subns, exp_q[0].subns);
    end
  endtask

  task automatic drain(string req);
    while (exp_q.size() > 0) begin
      check_head(req);
      step(0, 0, 0, 0, 1, 0);
    end
    check_head({req, " empty"});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 valid", st_valid, 0);
    check("R1 overflow", st_ovf, 0);

    // R2 R3 one frame, mixed identifier
    step(1, 3, 123456, 9'h1A5, 0, 0);
    drain("R2_R3 frame");

    // R3 identifier extremes and wrap order 511 then 0
    step(1, 127, 30'h3FFFFFFF, 511, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    drain("R3 fid511_fid0");

    // R5 pop on empty, then a fresh frame is intact
    step(0, 0, 0, 0, 1, 0);
    check_head("R5 empty pop");
    step(1, 9, 777, 42, 0, 0);
    check_head("R5 after empty pop");

    // R4 head steady without pop
    repeat (3) step(0, 0, 0, 0, 0, 0);
    check_head("R4 steady");
    drain("R4 order");

    // R6 fill to depth, then a refused push
    for (int i = 0; i < DEPTH / 2; i++) step(1, i, 1000 + i, 300 + i, 0, 0);
    check_head("R6 full");
    step(1, 55, 55, 55, 0, 0);
    check_head("R6 refused");
    // R6 push with pop at full count is still refused
    step(1, 56, 56, 56, 1, 0);
    check_head("R6 push+pop at full");
    // R7 clear coinciding with a drop keeps flag set
    step(1, 57, 57, 57, 0, 1);
    check_head("R7 set wins");
    step(0, 0, 0, 0, 0, 0);
    check_head("R7 sticky");
    drain("R4 fill order");
    step(0, 0, 0, 0, 0, 1);
    check_head("R7 cleared");

    // R9 push and pop together
    step(1, 4, 400, 40, 0, 0);
    step(1, 5, 500, 500, 1, 0);
    check_head("R9 push+pop");
    step(1, 6, 600, 256, 1, 0);
    check_head("R9 second");
    drain("R9 order");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule